// File: doc/BRIEF.md
# Capacitive Key Matrix Burst Scan Sequencer

This block is the digital timing engine behind a charge-transfer sensor for a key matrix of 8 drive rows (X) by 8 sense columns (Y). Once started, it visits all 64 key positions in a fixed order. For every key with a non-zero burst length it produces that many X pulses on the key's drive line. Around each rising X edge it opens that key's Y column into the integrator. It holds every other column clamped. It resets the integrator between keys. When the burst ends, it drives the key's offset code onto the X lines. After a programmed settling time it issues one ADC sample strobe tagged with the key index.

A small register file holds two values per key: the burst length (0 to 64 pulses, where 0 disables the key) and the offset code. This file can be written only while the sequencer is idle. The number of enabled keys is limited by a build-time cap of 32, 48 or 64. All delays are parameters counted in system clock cycles: the low and high times of an X pulse, the gate setup before the edge, the dwell after it, and the settling time before the sample.

Top module: `cmx_burst_seq`

## Requirements
- R1: After reset the sequencer is idle: busy, scan_done, smp_stb, gate_en and wr_err are 0, x_drv is 0, y_clamp is all ones, and int_rst is at its active level.
- R2: A scan triggered by start visits key index k = 8*Y + X in ascending order, so X advances fastest. During key k the pulses go on X line k mod 8, y_sel equals k div 8, and smp_key equals k.
- R3: Within a key's burst, x_drv is one-hot during the high phase, and the number of X rising edges equals that key's burst length (1 to 64).
- R4: A key whose burst length is 0 is skipped. It produces no X pulse and no sample strobe.
- R5: gate_en rises exactly T_SETUP cycles before each X rising edge and stays high for exactly T_SETUP+T_DWELL cycles. It then falls while X is still high.
- R6: While gate_en is high, y_clamp is all ones except a 0 on the current column. While gate_en is low, y_clamp is all ones.
- R7: After the final pulse of a burst, x_drv carries the key's offset code for T_SETTLE cycles. A one-cycle smp_stb follows, with x_drv still showing the offset code.
- R8: int_rst is at its active level while idle and between keys. It is at its inactive level from the first pulse phase of a burst until that key's sample strobe.
- R9: After the last key position has been handled, scan_done is high for exactly one cycle and busy then falls.
- R10: A register write (wr_sel 0 = burst length, 1 = offset) made while busy is ignored, and wr_err is high in the following cycle.
- R11: At reset, keys below KEY_CAP have burst length DEF_BURST and the other keys have 0. A burst-length write is rejected, with wr_err high in the following cycle, if the value exceeds 64 or if it would raise the count of enabled keys above KEY_CAP.
- R12: The active level of int_rst equals the clamp_pol input: 1 means active high and 0 means active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins one full scan when idle |
| clamp_pol | input | 1 | Active level of int_rst |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 1 | 0 selects burst length, 1 selects offset code |
| wr_key | input | 6 | Key index written |
| wr_data | input | 8 | Write value |
| wr_err | output | 1 | Previous write was rejected |
| busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle pulse at the end of a scan |
| x_drv | output | 8 | X drive lines: pulses, then the offset code |
| y_sel | output | 3 | Column select code |
| y_clamp | output | 8 | Per-column clamp, 1 = held at ground |
| gate_en | output | 1 | Charge gate closed |
| int_rst | output | 1 | Integrator reset, polarity set by clamp_pol |
| smp_stb | output | 1 | ADC sample strobe |
| smp_key | output | 6 | Key index carried with the strobe |

## Verification
Two functions can collide in one cycle: a register write arriving while a burst is running, and the burst reading that same key's offset to drive the X lines. The bench issues an offset write to key 0 a few cycles after start, while key 0's burst is in progress. It then requires both that wr_err rises and that the later strobe for key 0 shows the old offset. A second pairing is gate setup against the X edge: every rising X edge is judged against how long gate_en has already been high in that same sample.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEEK,
      ST_LO,
      ST_HI,
      ST_OFS,
      ST_SMP,
      ST_DONE
   } cmx_st_e;

   localparam logic SEL_BURST = 1'b0;
   localparam logic SEL_OFS   = 1'b1;

   localparam int unsigned MAX_BURST = 64;

endpackage

// File: rtl/cmx_keycfg.sv
module cmx_keycfg
   import cmx_pkg::*;
#(
   parameter int NKEY      = 64,
   parameter int KW        = 6,
   parameter int OFS_W     = 8,
   parameter int BL_W      = 7,
   parameter int WR_W      = 8,
   parameter int KEY_CAP   = 64,
   parameter int DEF_BURST = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [KW-1:0]    wr_key,
   input  logic [WR_W-1:0]  wr_data,
   output logic             wr_err,
   input  logic [KW-1:0]    rd_key,
   output logic [BL_W-1:0]  rd_bl,
   output logic [OFS_W-1:0] rd_ofs
);

   localparam int CNT_W = $clog2(NKEY + 1);

   logic [BL_W-1:0]  bl_q  [NKEY];
   logic [OFS_W-1:0] ofs_q [NKEY];
   logic [CNT_W-1:0] cnt_q;

   int unsigned new_cnt;
   logic        reject;
   logic        acc_bl, acc_ofs;

   always_comb begin
      new_cnt = int'(cnt_q);
      if (bl_q[wr_key] != '0) new_cnt = new_cnt - 1;
      if (wr_data != '0)      new_cnt = new_cnt + 1;
      reject = busy;
      if (wr_sel == SEL_BURST &&
          (int'(wr_data) > int'(MAX_BURST) || new_cnt > KEY_CAP))
         reject = 1'b1;
      acc_bl  = wr_en && !reject && wr_sel == SEL_BURST;
      acc_ofs = wr_en && !reject && wr_sel == SEL_OFS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NKEY; k++) begin
            bl_q[k]  <= (k < KEY_CAP) ? BL_W'(DEF_BURST) : '0;
            ofs_q[k] <= '0;
         end
         cnt_q  <= CNT_W'(KEY_CAP);
         wr_err <= 1'b0;
      end else begin
         wr_err <= wr_en && reject;
         if (acc_bl) begin
            bl_q[wr_key] <= wr_data[BL_W-1:0];
            cnt_q        <= CNT_W'(new_cnt);
         end
         if (acc_ofs) ofs_q[wr_key] <= wr_data[OFS_W-1:0];
      end
   end

   assign rd_bl  = bl_q[rd_key];
   assign rd_ofs = ofs_q[rd_key];

   // R11: enabled-key count never exceeds the cap
   a_r11_cap_kept: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= KEY_CAP);

   // R10: a write during a scan is flagged
   a_r10_busy_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> wr_err);

endmodule

// File: rtl/cmx_seq_fsm.sv
module cmx_seq_fsm
   import cmx_pkg::*;
#(
   parameter int NKEY     = 64,
   parameter int KW       = 6,
   parameter int BL_W     = 7,
   parameter int CW       = 8,
   parameter int T_XLO    = 4,
   parameter int T_XHI    = 4,
   parameter int T_SETTLE = 384
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [BL_W-1:0] cur_bl,
   output cmx_st_e         st_o,
   output logic [KW-1:0]   key_o,
   output logic [CW-1:0]   ph_o
);

   cmx_st_e         st_q;
   logic [KW-1:0]   key_q;
   logic [CW-1:0]   ph_q;
   logic [BL_W-1:0] left_q;
   logic            last;

   assign last = (key_q == KW'(NKEY - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         key_q  <= '0;
         ph_q   <= '0;
         left_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               key_q <= '0;
               st_q  <= ST_SEEK;
            end
            ST_SEEK: begin
               if (cur_bl == '0) begin
                  if (last) st_q  <= ST_DONE;
                  else      key_q <= key_q + 1'b1;
               end else begin
                  left_q <= cur_bl;
                  ph_q   <= '0;
                  st_q   <= ST_LO;
               end
            end
            ST_LO: begin
               if (ph_q == CW'(T_XLO - 1)) begin
                  ph_q <= '0;
                  st_q <= ST_HI;
               end else ph_q <= ph_q + 1'b1;
            end
            ST_HI: begin
               if (ph_q == CW'(T_XHI - 1)) begin
                  ph_q <= '0;
                  if (left_q == BL_W'(1)) st_q <= ST_OFS;
                  else begin
                     left_q <= left_q - 1'b1;
                     st_q   <= ST_LO;
                  end
               end else ph_q <= ph_q + 1'b1;
            end
            ST_OFS: begin
               if (ph_q == CW'(T_SETTLE - 1)) begin
                  ph_q <= '0;
                  st_q <= ST_SMP;
               end else ph_q <= ph_q + 1'b1;
            end
            ST_SMP: begin
               if (last) st_q <= ST_DONE;
               else begin
                  key_q <= key_q + 1'b1;
                  st_q  <= ST_SEEK;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign st_o  = st_q;
   assign key_o = key_q;
   assign ph_o  = ph_q;

   // R4: a disabled key never enters a pulse phase
   a_r4_skip_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SEEK && cur_bl == '0) |=> st_q != ST_LO);

   // R7: a sample is always preceded by the settle phase
   a_r7_settle_before_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SMP) |-> $past(st_q) == ST_OFS);

   // R2: keys advance by one after each sample
   a_r2_key_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SMP && !last) |=> key_q == $past(key_q) + 1'b1);

   // R9: the done state lasts one cycle
   a_r9_done_once: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DONE) |=> st_q == ST_IDLE);

endmodule

// File: rtl/cmx_line_drv.sv
module cmx_line_drv
   import cmx_pkg::*;
#(
   parameter int NX      = 8,
   parameter int NY      = 8,
   parameter int KW      = 6,
   parameter int CW      = 8,
   parameter int T_XLO   = 4,
   parameter int T_SETUP = 1,
   parameter int T_DWELL = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  cmx_st_e               st,
   input  logic [KW-1:0]         key,
   input  logic [CW-1:0]         ph,
   input  logic [NX-1:0]         ofs,
   input  logic                  clamp_pol,
   output logic [NX-1:0]         x_drv,
   output logic [$clog2(NY)-1:0] y_sel,
   output logic [NY-1:0]         y_clamp,
   output logic                  gate_en,
   output logic                  int_rst
);

   localparam int XW = $clog2(NX);
   localparam int YW = $clog2(NY);

   logic [XW-1:0] xi;
   logic          int_act;

   assign xi    = key[XW-1:0];
   assign y_sel = key[KW-1:XW];

   always_comb begin
      case (st)
         ST_HI:          x_drv = NX'(1) << xi;
         ST_OFS, ST_SMP: x_drv = ofs;
         default:        x_drv = '0;
      endcase
   end

   assign gate_en = (st == ST_LO && ph >= CW'(T_XLO - T_SETUP)) ||
                    (st == ST_HI && ph <  CW'(T_DWELL));

   for (genvar j = 0; j < NY; j++) begin : g_clamp
      assign y_clamp[j] = !(gate_en && y_sel == YW'(j));
   end

   assign int_act = (st == ST_IDLE) || (st == ST_SEEK) || (st == ST_DONE);
   assign int_rst = clamp_pol ? int_act : !int_act;

   // R5: gate is already closed in the cycle before the X edge
   a_r5_gate_leads_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HI && ph == '0) |-> $past(gate_en));

   // R6: exactly one column released while gated
   a_r6_one_column_open: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en |-> $countones(y_clamp) == NY - 1);

   // R3: at most one X line high during a pulse
   a_r3_single_x: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HI || st == ST_LO) |-> $onehot0(x_drv));

endmodule

// File: rtl/cmx_burst_seq.sv
module cmx_burst_seq
   import cmx_pkg::*;
#(
   parameter int NX        = 8,
   parameter int NY        = 8,
   parameter int KEY_CAP   = 64,
   parameter int DEF_BURST = 4,
   parameter int WR_W      = 8,
   parameter int T_XLO     = 12,
   parameter int T_XHI     = 24,
   parameter int T_SETUP   = 1,
   parameter int T_DWELL   = 8,
   parameter int T_SETTLE  = 384
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      clamp_pol,
   input  logic                      wr_en,
   input  logic                      wr_sel,
   input  logic [$clog2(NX*NY)-1:0]  wr_key,
   input  logic [WR_W-1:0]           wr_data,
   output logic                      wr_err,
   output logic                      busy,
   output logic                      scan_done,
   output logic [NX-1:0]             x_drv,
   output logic [$clog2(NY)-1:0]     y_sel,
   output logic [NY-1:0]             y_clamp,
   output logic                      gate_en,
   output logic                      int_rst,
   output logic                      smp_stb,
   output logic [$clog2(NX*NY)-1:0]  smp_key
);

   localparam int NKEY = NX * NY;
   localparam int KW   = $clog2(NKEY);
   localparam int BL_W = $clog2(MAX_BURST + 1);
   localparam int TMAX = (T_SETTLE > T_XHI) ?
                         ((T_SETTLE > T_XLO) ? T_SETTLE : T_XLO) :
                         ((T_XHI > T_XLO) ? T_XHI : T_XLO);
   localparam int CW   = $clog2(TMAX + 1);

   if (NX != (1 << $clog2(NX)) || NY != (1 << $clog2(NY))) begin : g_chk_pow2
      $error("matrix sides must be powers of two");
   end
   if (KEY_CAP < 1 || KEY_CAP > NKEY) begin : g_chk_cap
      $error("KEY_CAP out of range");
   end
   if (DEF_BURST < 1 || DEF_BURST > int'(MAX_BURST)) begin : g_chk_def
      $error("DEF_BURST out of range");
   end
   if (WR_W < NX || WR_W < BL_W) begin : g_chk_wrw
      $error("WR_W too narrow");
   end
   if (T_SETUP < 1 || T_SETUP >= T_XLO || T_DWELL < 1 || T_DWELL >= T_XHI)
   begin : g_chk_win
      $error("gate window must fit inside the pulse phases");
   end
   if (T_SETTLE < 1) begin : g_chk_settle
      $error("T_SETTLE must be at least one cycle");
   end

   cmx_st_e         st;
   logic [KW-1:0]   key;
   logic [CW-1:0]   ph;
   logic [BL_W-1:0] cur_bl;
   logic [NX-1:0]   cur_ofs;

   assign busy      = (st != ST_IDLE);
   assign scan_done = (st == ST_DONE);
   assign smp_stb   = (st == ST_SMP);
   assign smp_key   = key;

   cmx_keycfg #(
      .NKEY(NKEY), .KW(KW), .OFS_W(NX), .BL_W(BL_W), .WR_W(WR_W),
      .KEY_CAP(KEY_CAP), .DEF_BURST(DEF_BURST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .busy(busy),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_key(wr_key), .wr_data(wr_data),
      .wr_err(wr_err), .rd_key(key), .rd_bl(cur_bl), .rd_ofs(cur_ofs)
   );

   cmx_seq_fsm #(
      .NKEY(NKEY), .KW(KW), .BL_W(BL_W), .CW(CW),
      .T_XLO(T_XLO), .T_XHI(T_XHI), .T_SETTLE(T_SETTLE)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .cur_bl(cur_bl),
      .st_o(st), .key_o(key), .ph_o(ph)
   );

   cmx_line_drv #(
      .NX(NX), .NY(NY), .KW(KW), .CW(CW),
      .T_XLO(T_XLO), .T_SETUP(T_SETUP), .T_DWELL(T_DWELL)
   ) u_drv (
      .clk(clk), .rst_n(rst_n), .st(st), .key(key), .ph(ph), .ofs(cur_ofs),
      .clamp_pol(clamp_pol), .x_drv(x_drv), .y_sel(y_sel),
      .y_clamp(y_clamp), .gate_en(gate_en), .int_rst(int_rst)
   );

   // R9: scan_done is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> !scan_done && !busy);

   // R8: no sample while the integrator is held in reset
   a_r8_sample_released: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |-> int_rst != clamp_pol);

endmodule

// File: tb/cmx_burst_seq_tb.sv
module cmx_burst_seq_tb_top;

   localparam int CAP = 32;
   localparam int DEFB = 2;
   localparam int TXL = 4, TXH = 5, TSU = 2, TDW = 3, TST = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, clamp_pol = 1'b1;
   logic       wr_en = 1'b0, wr_sel = 1'b0;
   logic [5:0] wr_key = '0;
   logic [7:0] wr_data = '0;
   logic       wr_err, busy, scan_done, gate_en, int_rst, smp_stb;
   logic [7:0] x_drv, y_clamp;
   logic [2:0] y_sel;
   logic [5:0] smp_key;

   always #4 clk = ~clk;

   cmx_burst_seq #(
      .NX(8), .NY(8), .KEY_CAP(CAP), .DEF_BURST(DEFB), .WR_W(8),
      .T_XLO(TXL), .T_XHI(TXH), .T_SETUP(TSU), .T_DWELL(TDW), .T_SETTLE(TST)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .clamp_pol(clamp_pol),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_key(wr_key), .wr_data(wr_data),
      .wr_err(wr_err), .busy(busy), .scan_done(scan_done), .x_drv(x_drv),
      .y_sel(y_sel), .y_clamp(y_clamp), .gate_en(gate_en), .int_rst(int_rst),
      .smp_stb(smp_stb), .smp_key(smp_key)
   );

   typedef struct { int key; int ofs; int bl; } exp_t;
   exp_t q[$];

   int n_chk = 0, n_bad = 0;
   int m_bl[64];
   int m_ofs[64];
   int m_cnt;
   bit ended = 0;

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // monitor: pulses, gate window, clamps, samples
   int pulses = 0, gate_run = 0, x_run = 0, done_seen = 0;
   logic [7:0] prev_x = '0;
   logic       prev_gate = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (gate_en) gate_run++;
         if (prev_x == 8'h00 && x_drv != 8'h00) begin
            if (q.size() == 0) chk(0, "R4 unexpected pulse", int'(x_drv), 0);
            else begin
               pulses++;
               chk(x_drv == (8'h01 << (q[0].key % 8)), "R2 pulse line", int'(x_drv),
                   int'(8'h01 << (q[0].key % 8)));
               chk(int'(y_sel) == q[0].key / 8, "R2 column select", int'(y_sel), q[0].key / 8);
               chk(gate_en && gate_run == TSU + 1, "R5 gate setup", gate_run, TSU + 1);
            end
         end
         if (prev_gate && !gate_en) begin
            chk(gate_run == TSU + TDW, "R5 gate width", gate_run, TSU + TDW);
            chk(x_drv != 8'h00, "R5 gate opens while X high", int'(x_drv), 1);
         end
         if (!gate_en) gate_run = 0;
         if (gate_en) begin
            chk(y_clamp == ~(8'h01 << y_sel), "R6 column released", int'(y_clamp),
                int'(~(8'h01 << y_sel)));
            chk(int_rst != clamp_pol, "R8 integrator released", int'(int_rst), int'(!clamp_pol));
         end else
            chk(y_clamp == 8'hFF, "R6 all clamped", int'(y_clamp), 255);
         if (x_drv == prev_x) x_run++;
         else x_run = 1;
         if (smp_stb) begin
            if (q.size() == 0) chk(0, "R4 unexpected sample", int'(smp_key), -1);
            else begin
               chk(int'(smp_key) == q[0].key, "R2 sample order", int'(smp_key), q[0].key);
               chk(pulses == q[0].bl, "R3 pulse count", pulses, q[0].bl);
               chk(int'(x_drv) == q[0].ofs, "R7 offset code", int'(x_drv), q[0].ofs);
               chk(x_run >= TST + 1, "R7 settle time", x_run, TST + 1);
               chk(int_rst != clamp_pol, "R8 released at sample", int'(int_rst), int'(!clamp_pol));
               void'(q.pop_front());
            end
            pulses = 0;
         end
         if (scan_done) done_seen++;
         prev_x = x_drv;
         prev_gate = gate_en;
      end
   end

   task automatic do_wr(bit sel, int key, int data, bit bsy, string req);
      bit rej;
      int nc;
      rej = bsy;
      if (!sel) begin
         nc = m_cnt - ((m_bl[key] != 0) ? 1 : 0) + ((data != 0) ? 1 : 0);
         if (data > 64 || nc > CAP) rej = 1;
      end
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_key = 6'(key); wr_data = 8'(data);
      @(negedge clk);
      wr_en = 1'b0;
      chk(wr_err == rej, req, int'(wr_err), int'(rej));
      if (!rej) begin
         if (!sel) begin m_cnt = nc; m_bl[key] = data; end
         else m_ofs[key] = data;
      end
   endtask

   task automatic run_scan(bit busy_write);
      for (int k = 0; k < 64; k++)
         if (m_bl[k] != 0) q.push_back('{key: k, ofs: m_ofs[k], bl: m_bl[k]});
      done_seen = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
      if (busy_write) begin
         repeat (2) @(negedge clk);
         do_wr(1'b1, 0, 8'h3C, 1'b1, "R10 write while busy rejected");
      end
      while (busy) @(negedge clk);
      chk(q.size() == 0, "R4 all expected samples seen", q.size(), 0);
      chk(done_seen == 1, "R9 single done pulse", done_seen, 1);
      chk(int_rst == clamp_pol, "R12 idle reset level", int'(int_rst), int'(clamp_pol));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      for (int k = 0; k < 64; k++) begin
         m_bl[k] = (k < CAP) ? DEFB : 0;
         m_ofs[k] = 0;
      end
      m_cnt = CAP;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && scan_done == 0 && smp_stb == 0, "R1 idle flags", int'(busy), 0);
      chk(x_drv == 8'h00, "R1 x lines low", int'(x_drv), 0);
      chk(y_clamp == 8'hFF && gate_en == 0, "R1 clamps held", int'(y_clamp), 255);
      chk(int_rst == 1'b1 && wr_err == 0, "R1 integrator reset", int'(int_rst), 1);

      // default table: keys below the cap at DEF_BURST
      run_scan(1'b0);

      // R11 cap and range limits
      do_wr(1'b0, 40, 3, 1'b0, "R11 over cap rejected");
      do_wr(1'b0, 5, 0, 1'b0, "R11 disable key accepted");
      do_wr(1'b0, 40, 3, 1'b0, "R11 enable within cap");
      do_wr(1'b0, 10, 65, 1'b0, "R11 length above 64 rejected");
      do_wr(1'b0, 10, 0, 1'b0, "R11 disable key accepted");
      do_wr(1'b0, 63, 64, 1'b0, "R11 max length accepted");
      do_wr(1'b0, 20, 1, 1'b0, "R11 nonzero change with full count");
      do_wr(1'b0, 0, 1, 1'b0, "R3 single pulse length");
      do_wr(1'b1, 0, 8'h5A, 1'b0, "R7 offset write");
      do_wr(1'b1, 40, 8'hC3, 1'b0, "R7 offset write");
      do_wr(1'b1, 63, 8'h81, 1'b0, "R7 offset write");
      do_wr(1'b1, 31, 8'h01, 1'b0, "R7 offset write");

      // skipped keys, single and maximum bursts, last position
      run_scan(1'b0);

      // inverted reset polarity, plus a colliding write
      @(negedge clk);
      clamp_pol = 1'b0;
      @(negedge clk);
      chk(int_rst == 1'b0, "R12 active low when idle", int'(int_rst), 0);
      run_scan(1'b1);

      finish_run();
   end

endmodule